// File: doc/BRIEF.md
# Retention Tail Search Sequencer

This block measures how long the cells of a small memory region hold a stored one. A single test pass writes a one into every cell of the region on consecutive cycles. It then idles for a programmed number of cycles and reads every cell back on consecutive cycles. Any cell that returns zero is reported on a failing-address stream. The wait seen by each cell is the region size in cycles plus the idle count, so a requested delay `d` turns into an idle count of `max(d - cells, 0)`.

A search controller picks the delays that passes run at. It looks for the tail, which is the shortest delay at which some cell fails, and it never tests a delay above the configured refresh limit. In the grow phase the delay starts at the configured initial value and is multiplied by a fixed factor after every clean pass, clamped at the limit. The first failing pass ends the grow phase. The refine phase then bisects between the last clean delay and the first failing one, until the gap is no wider than the resolution. If a pass at the limit is clean, the block reports that no tail exists below the limit.

The pass engine has six states: PE_IDLE, PE_WRITE, PE_WAIT, PE_READ, PE_DRAIN and PE_DONE. Its transitions are:
- PE_IDLE to PE_WRITE on a launch from the search controller.
- PE_WRITE to PE_WAIT, or straight to PE_READ when the idle count is zero, after the last address.
- PE_WAIT to PE_READ when the idle count expires.
- PE_READ to PE_DRAIN after the last address.
- PE_DRAIN to PE_DONE, which takes in the last read data.
- PE_DONE to PE_IDLE, with the pass result reported.

The search controller has five states: SR_IDLE, SR_GROW, SR_GROW_WAIT, SR_REFINE and SR_REFINE_WAIT. Its transitions are:
- SR_IDLE to SR_GROW on start.
- SR_GROW to SR_GROW_WAIT, which launches a pass.
- SR_GROW_WAIT back to SR_GROW on a clean pass below the limit.
- SR_GROW_WAIT to SR_IDLE on a clean pass at the limit (no tail), or on a failing pass whose gap is already narrow.
- SR_GROW_WAIT to SR_REFINE on a failing pass whose gap is still wide.
- SR_REFINE to SR_REFINE_WAIT, which launches a pass.
- SR_REFINE_WAIT back to SR_REFINE while the gap stays wide.
- SR_REFINE_WAIT to SR_IDLE once the gap is narrow.

Top module: `retention_tail_search`

## Requirements
- R1: In a pass, `mem_we` is high for exactly `2^(ROW_W+COL_W)` consecutive cycles with `mem_wdata` = 1. The addresses run 0, 1, 2 … upward, with the address formed as {row, column}.
- R2: The cycles from the write of a cell to the read of that cell equal `max(d, cells)`, where `d` is the delay of the pass.
- R3: Reads run as one unbroken burst of exactly `cells` cycles at ascending addresses from 0. Read data returns one cycle after the read, and `mem_we` and `mem_re` are never high together.
- R4: `fail_valid` pulses with `fail_addr` in the cycle after a read whose data is zero, once for every such read and at no other time.
- R5: `pass_fail` is 0 from the first write cycle of a pass. It goes to 1 on any zero read in that pass and keeps its value until the next pass starts, including after the search ends.
- R6: The first pass runs at `min(max(cfg_init_dly,1), cfg_tref)`. After each clean pass in the grow phase, the next delay is the current delay times `max(cfg_mult,2)`, clamped at `cfg_tref`.
- R7: After the first failing pass, each pass runs at `lo + (hi-lo)/2`. Here `lo` is the last clean delay (0 if there is none) and `hi` is the last failing delay. The search stops when `hi-lo <= max(cfg_res,1)` and reports `tail_dly = hi`.
- R8: A clean pass at `cfg_tref` ends the search with `no_tail` = 1 and `tail_dly = cfg_tref`, and `no_tail` is only ever high together with `done`.
- R9: `busy` rises in the cycle after an accepted `start` and falls in the cycle `done` rises. `done` stays high until the next accepted start. A `start` while busy is ignored, and configuration is taken only at an accepted start.
- R10: After reset, `busy`, `done`, `no_tail`, `fail_valid`, `mem_we` and `mem_re` are 0, and no memory access happens while the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a search when idle |
| cfg_init_dly | input | DLY_W | First delay, in cycles |
| cfg_mult | input | MULT_W | Grow-phase multiplier (values below 2 act as 2) |
| cfg_tref | input | DLY_W | Refresh limit, the largest delay tested |
| cfg_res | input | DLY_W | Resolution of the refine phase (0 acts as 1) |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, held until next start |
| tail_dly | output | DLY_W | Tail delay found, or cfg_tref when there is no tail |
| no_tail | output | 1 | No cell failed at the refresh limit |
| pass_fail | output | 1 | Latest pass saw a zero read |
| fail_valid | output | 1 | A zero read is reported this cycle |
| fail_addr | output | ROW_W+COL_W | Address of the zero read |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ROW_W+COL_W | Memory address {row, column} |
| mem_wdata | output | 1 | Memory write data |
| mem_rdata | input | 1 | Memory read data, one cycle after mem_re |

## Verification
The checker watches the burst shapes on every cycle: writes and reads never overlap, and each burst starts at address 0 and steps by one. It also checks that failure reports appear only during a search, that `busy` and `done` are exclusive, that `done` holds, and that `no_tail` implies `done`. Other properties need a memory model with per-cell hold times, so only the bench scenarios can show them. These are the exact wait each cell experiences, the sequence of delays chosen by the grow and refine phases, the final tail value, the fail stream against the cells that really decayed, and the rejection of a mid-search start.

// File: rtl/rts_pkg.sv
package rts_pkg;

    // Pass engine: one write burst, optional idle, one read burst
    typedef enum logic [2:0] {
        PE_IDLE,
        PE_WRITE,
        PE_WAIT,
        PE_READ,
        PE_DRAIN,
        PE_DONE
    } pe_state_t;

    // Search controller: grow phase then refine phase
    typedef enum logic [2:0] {
        SR_IDLE,
        SR_GROW,
        SR_GROW_WAIT,
        SR_REFINE,
        SR_REFINE_WAIT
    } sr_state_t;

endpackage

// File: rtl/rts_pass_engine.sv
module rts_pass_engine
    import rts_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DLY_W-1:0]  dly,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wdata,
    input  logic              mem_rdata,
    output logic              pass_done,
    output logic              pass_fail,
    output logic              fail_valid,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int unsigned       CELLS   = 1 << ADDR_W;
    localparam logic [DLY_W:0]    CELLS_X = (DLY_W+1)'(CELLS);
    localparam logic [ADDR_W-1:0] LAST    = {ADDR_W{1'b1}};

    pe_state_t          st_q, st_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [DLY_W-1:0]   idle_q;
    logic [DLY_W-1:0]   idle_calc;
    logic [DLY_W:0]     dly_x;
    logic               rd_pend_q;
    logic [ADDR_W-1:0]  rd_addr_q;
    logic               fail_q;

    // Idle count: requested delay minus the burst length, floored at zero
    always_comb begin
        dly_x = {1'b0, dly};
        if (dly_x > CELLS_X) begin
            idle_calc = DLY_W'(dly_x - CELLS_X);
        end else begin
            idle_calc = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PE_IDLE: begin
                if (go) st_d = PE_WRITE;
            end
            PE_WRITE: begin
                if (addr_q == LAST) begin
                    st_d = (idle_q == '0) ? PE_READ : PE_WAIT;
                end
            end
            PE_WAIT: begin
                if (idle_q == DLY_W'(1)) st_d = PE_READ;
            end
            PE_READ: begin
                if (addr_q == LAST) st_d = PE_DRAIN;
            end
            PE_DRAIN: st_d = PE_DONE;
            PE_DONE:  st_d = PE_IDLE;
            default:  st_d = PE_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            idle_q    <= '0;
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
            fail_q    <= 1'b0;
        end else begin
            rd_pend_q <= (st_q == PE_READ);
            rd_addr_q <= addr_q;
            unique case (st_q)
                PE_IDLE: begin
                    if (go) begin
                        addr_q <= '0;
                        idle_q <= idle_calc;
                        fail_q <= 1'b0;
                    end
                end
                PE_WRITE: addr_q <= addr_q + 1'b1;
                PE_WAIT:  idle_q <= idle_q - 1'b1;
                PE_READ:  addr_q <= addr_q + 1'b1;
                default: ;
            endcase
            if (fail_valid) fail_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        mem_we     = (st_q == PE_WRITE);
        mem_re     = (st_q == PE_READ);
        mem_wdata  = (st_q == PE_WRITE);
        mem_addr   = addr_q;
        pass_done  = (st_q == PE_DONE);
        pass_fail  = fail_q;
        fail_valid = rd_pend_q & ~mem_rdata;
        fail_addr  = rd_addr_q;
    end

endmodule

// File: rtl/rts_step_calc.sv
module rts_step_calc #(
    parameter int DLY_W  = 16,
    parameter int MULT_W = 4
) (
    input  logic [DLY_W-1:0]  cur,
    input  logic [MULT_W-1:0] mult,
    input  logic [DLY_W-1:0]  tref,
    input  logic [DLY_W-1:0]  res,
    input  logic [DLY_W-1:0]  lo,
    input  logic [DLY_W-1:0]  hi,
    output logic [DLY_W-1:0]  grow_next,
    output logic [DLY_W-1:0]  mid,
    output logic              narrow
);

    localparam int PW = DLY_W + MULT_W;

    logic [MULT_W-1:0] mult_eff;
    logic [DLY_W-1:0]  res_eff;
    logic [PW-1:0]     prod;
    logic [DLY_W-1:0]  gap;

    always_comb begin
        mult_eff  = (mult < MULT_W'(2)) ? MULT_W'(2) : mult;
        res_eff   = (res == '0) ? DLY_W'(1) : res;
        prod      = PW'(cur) * PW'(mult_eff);
        grow_next = (prod >= PW'(tref)) ? tref : prod[DLY_W-1:0];
        gap       = hi - lo;
        mid       = lo + (gap >> 1);
        narrow    = (gap <= res_eff);
    end

endmodule

// File: rtl/rts_search_ctl.sv
module rts_search_ctl
    import rts_pkg::*;
#(
    parameter int DLY_W  = 16,
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DLY_W-1:0]  cfg_init_dly,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [DLY_W-1:0]  cfg_tref,
    input  logic [DLY_W-1:0]  cfg_res,
    input  logic              pass_done,
    input  logic              pass_fail,
    output logic              go,
    output logic [DLY_W-1:0]  go_dly,
    output logic              busy,
    output logic              done,
    output logic [DLY_W-1:0]  tail_dly,
    output logic              no_tail
);

    sr_state_t          st_q, st_d;
    logic [DLY_W-1:0]   cur_q, lo_q, hi_q, tail_q;
    logic [MULT_W-1:0]  mult_q;
    logic [DLY_W-1:0]   tref_q, res_q;
    logic               done_q, no_tail_q;

    logic [DLY_W-1:0]   init_eff, first_dly;
    logic [DLY_W-1:0]   cand_lo, cand_hi;
    logic [DLY_W-1:0]   grow_next, mid;
    logic               narrow;

    // Bracket after the current pass result
    always_comb begin
        init_eff  = (cfg_init_dly == '0) ? DLY_W'(1) : cfg_init_dly;
        first_dly = (init_eff > cfg_tref) ? cfg_tref : init_eff;
        cand_lo   = pass_fail ? lo_q  : cur_q;
        cand_hi   = pass_fail ? cur_q : hi_q;
    end

    rts_step_calc #(
        .DLY_W  (DLY_W),
        .MULT_W (MULT_W)
    ) u_step (
        .cur       (cur_q),
        .mult      (mult_q),
        .tref      (tref_q),
        .res       (res_q),
        .lo        (cand_lo),
        .hi        (cand_hi),
        .grow_next (grow_next),
        .mid       (mid),
        .narrow    (narrow)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SR_IDLE: begin
                if (start) st_d = SR_GROW;
            end
            SR_GROW: st_d = SR_GROW_WAIT;
            SR_GROW_WAIT: begin
                if (pass_done) begin
                    if (pass_fail) begin
                        st_d = narrow ? SR_IDLE : SR_REFINE;
                    end else if (cur_q == tref_q) begin
                        st_d = SR_IDLE;
                    end else begin
                        st_d = SR_GROW;
                    end
                end
            end
            SR_REFINE: st_d = SR_REFINE_WAIT;
            SR_REFINE_WAIT: begin
                if (pass_done) st_d = narrow ? SR_IDLE : SR_REFINE;
            end
            default: st_d = SR_IDLE;
        endcase
    end

    // Search registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            tail_q    <= '0;
            mult_q    <= '0;
            tref_q    <= '0;
            res_q     <= '0;
            done_q    <= 1'b0;
            no_tail_q <= 1'b0;
        end else begin
            unique case (st_q)
                SR_IDLE: begin
                    if (start) begin
                        mult_q    <= cfg_mult;
                        tref_q    <= cfg_tref;
                        res_q     <= cfg_res;
                        cur_q     <= first_dly;
                        lo_q      <= '0;
                        hi_q      <= '0;
                        tail_q    <= '0;
                        done_q    <= 1'b0;
                        no_tail_q <= 1'b0;
                    end
                end
                SR_GROW_WAIT: begin
                    if (pass_done) begin
                        lo_q <= cand_lo;
                        hi_q <= cand_hi;
                        if (pass_fail) begin
                            if (narrow) begin
                                tail_q <= cand_hi;
                                done_q <= 1'b1;
                            end else begin
                                cur_q <= mid;
                            end
                        end else if (cur_q == tref_q) begin
                            tail_q    <= tref_q;
                            no_tail_q <= 1'b1;
                            done_q    <= 1'b1;
                        end else begin
                            cur_q <= grow_next;
                        end
                    end
                end
                SR_REFINE_WAIT: begin
                    if (pass_done) begin
                        lo_q <= cand_lo;
                        hi_q <= cand_hi;
                        if (narrow) begin
                            tail_q <= cand_hi;
                            done_q <= 1'b1;
                        end else begin
                            cur_q <= mid;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        go       = (st_q == SR_GROW) || (st_q == SR_REFINE);
        go_dly   = cur_q;
        busy     = (st_q != SR_IDLE);
        done     = done_q;
        tail_dly = tail_q;
        no_tail  = no_tail_q;
    end

endmodule

// File: rtl/retention_tail_search.sv
module retention_tail_search #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DLY_W  = 16,
    parameter int MULT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DLY_W-1:0]       cfg_init_dly,
    input  logic [MULT_W-1:0]      cfg_mult,
    input  logic [DLY_W-1:0]       cfg_tref,
    input  logic [DLY_W-1:0]       cfg_res,
    output logic                   busy,
    output logic                   done,
    output logic [DLY_W-1:0]       tail_dly,
    output logic                   no_tail,
    output logic                   pass_fail,
    output logic                   fail_valid,
    output logic [ROW_W+COL_W-1:0] fail_addr,
    output logic                   mem_we,
    output logic                   mem_re,
    output logic [ROW_W+COL_W-1:0] mem_addr,
    output logic                   mem_wdata,
    input  logic                   mem_rdata
);

    localparam int ADDR_W = ROW_W + COL_W;

    logic             go;
    logic [DLY_W-1:0] go_dly;
    logic             pass_done;

    rts_search_ctl #(
        .DLY_W  (DLY_W),
        .MULT_W (MULT_W)
    ) u_search (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_init_dly (cfg_init_dly),
        .cfg_mult     (cfg_mult),
        .cfg_tref     (cfg_tref),
        .cfg_res      (cfg_res),
        .pass_done    (pass_done),
        .pass_fail    (pass_fail),
        .go           (go),
        .go_dly       (go_dly),
        .busy         (busy),
        .done         (done),
        .tail_dly     (tail_dly),
        .no_tail      (no_tail)
    );

    rts_pass_engine #(
        .ADDR_W (ADDR_W),
        .DLY_W  (DLY_W)
    ) u_pass (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .dly        (go_dly),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .pass_done  (pass_done),
        .pass_fail  (pass_fail),
        .fail_valid (fail_valid),
        .fail_addr  (fail_addr)
    );

endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              no_tail,
    input logic              fail_valid,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);

    p_we_re_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_write_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> (mem_addr == '0));

    p_write_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    p_read_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_re) |-> (mem_addr == '0));

    p_read_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    p_fail_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid |-> busy);

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_notail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_tail |-> done);

    p_access_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

endmodule

bind retention_tail_search rts_checker #(
    .ADDR_W (ROW_W + COL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .no_tail    (no_tail),
    .fail_valid (fail_valid),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr)
);

// File: tb/retention_tail_search_test.sv
`timescale 1ns/1ps
module retention_tail_search_test;

    localparam int ROW_W  = 2;
    localparam int COL_W  = 2;
    localparam int AW     = ROW_W + COL_W;
    localparam int DLY_W  = 16;
    localparam int MULT_W = 4;
    localparam int CELLS  = 1 << AW;
    localparam int LOGSZ  = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DLY_W-1:0]  cfg_init_dly = '0;
    logic [MULT_W-1:0] cfg_mult = '0;
    logic [DLY_W-1:0]  cfg_tref = '0;
    logic [DLY_W-1:0]  cfg_res = '0;
    logic              busy, done, no_tail, pass_fail, fail_valid;
    logic [AW-1:0]     fail_addr, mem_addr;
    logic              mem_we, mem_re, mem_wdata;
    logic              mem_rdata = 1'b1;

    always #2.5 clk = ~clk;

    retention_tail_search #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DLY_W (DLY_W), .MULT_W (MULT_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cfg_init_dly (cfg_init_dly), .cfg_mult (cfg_mult),
        .cfg_tref (cfg_tref), .cfg_res (cfg_res),
        .busy (busy), .done (done), .tail_dly (tail_dly), .no_tail (no_tail),
        .pass_fail (pass_fail), .fail_valid (fail_valid), .fail_addr (fail_addr),
        .mem_we (mem_we), .mem_re (mem_re), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );
    logic [DLY_W-1:0] tail_dly;

    // ---------------- memory model with per-cell hold time ----------------
    int   hold [CELLS];
    int   wst  [CELLS];
    logic mval [CELLS];
    int   cyc = 0;
    int   el_log [LOGSZ];
    int   el_n = 0;
    logic exp_fv = 1'b0;
    logic [AW-1:0] exp_fa = '0;

    initial begin
        for (int i = 0; i < CELLS; i++) begin
            hold[i] = 1000;
            wst[i]  = 0;
            mval[i] = 1'b0;
        end
    end

    always @(posedge clk) begin
        int el;
        cyc    <= cyc + 1;
        exp_fv <= 1'b0;
        if (mem_we) begin
            mval[mem_addr] <= mem_wdata;
            wst[mem_addr]  <= cyc;
        end
        if (mem_re) begin
            el = cyc - wst[mem_addr];
            mem_rdata <= (el > hold[mem_addr]) ? 1'b0 : mval[mem_addr];
            exp_fv    <= (el > hold[mem_addr]) || !mval[mem_addr];
            exp_fa    <= mem_addr;
            if (mem_addr == '0 && el_n < LOGSZ) begin
                el_log[el_n] <= el;
                el_n <= el_n + 1;
            end
        end
    end

    // ---------------- port monitors (sampled at negedge) ----------------
    int   r1_err = 0, r3_err = 0, r4_err = 0, r5_err = 0;
    logic prev_we = 1'b0, prev_re = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int   wlen = 0, rlen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R1 write burst shape
            if (mem_we) begin
                if ((!prev_we && mem_addr != '0) ||
                    (prev_we && mem_addr != AW'(prev_addr + 1'b1)) || !mem_wdata)
                    r1_err <= r1_err + 1;
                wlen <= prev_we ? wlen + 1 : 1;
            end else if (prev_we && wlen != CELLS) begin
                r1_err <= r1_err + 1;
            end
            // R3 read burst shape
            if (mem_re) begin
                if ((!prev_re && mem_addr != '0) ||
                    (prev_re && mem_addr != AW'(prev_addr + 1'b1)))
                    r3_err <= r3_err + 1;
                rlen <= prev_re ? rlen + 1 : 1;
            end else if (prev_re && rlen != CELLS) begin
                r3_err <= r3_err + 1;
            end
            if (mem_we && mem_re) r3_err <= r3_err + 1;
            // R4 fail stream against decayed cells
            if (fail_valid != exp_fv || (exp_fv && fail_addr != exp_fa))
                r4_err <= r4_err + 1;
            // R5 cleared from the first write of a pass
            if (mem_we && mem_addr == '0 && pass_fail)
                r5_err <= r5_err + 1;
            prev_we   <= mem_we;
            prev_re   <= mem_re;
            prev_addr <= mem_addr;
        end
    end

    // ---------------- checking helpers ----------------
    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference search sequence (R6, R7, R8)
    int exp_d [64];
    int exp_n, exp_tail;
    bit exp_nt, exp_lastfail;

    function automatic int wait_of(input int d);
        return (d > CELLS) ? d : CELLS;
    endfunction

    task automatic model(input int init, input int mult, input int tref,
                         input int res, input int minhold);
        int cur, lo, hi, me, re;
        bit f, grow;
        me = (mult < 2) ? 2 : mult;
        re = (res == 0) ? 1 : res;
        cur = (init == 0) ? 1 : init;
        if (cur > tref) cur = tref;
        lo = 0; hi = 0; grow = 1; exp_n = 0; exp_nt = 0;
        while (exp_n < 64) begin
            exp_d[exp_n] = cur;
            exp_n++;
            f = wait_of(cur) > minhold;
            exp_lastfail = f;
            if (f) hi = cur; else lo = cur;
            if (grow && !f) begin
                if (cur == tref) begin
                    exp_nt = 1; exp_tail = tref;
                    break;
                end
                cur = (cur * me >= tref) ? tref : cur * me;
            end else begin
                grow = 0;
                if (hi - lo <= re) begin
                    exp_tail = hi;
                    break;
                end
                cur = lo + (hi - lo) / 2;
            end
        end
    endtask

    task automatic run_case(input string name, input int init, input int mult,
                            input int tref, input int res, input bit disturb);
        int minhold, base, b1, b3, b4, b5, lim;
        bit lastpf;
        minhold = hold[0];
        for (int i = 1; i < CELLS; i++) if (hold[i] < minhold) minhold = hold[i];
        model(init, mult, tref, res, minhold);
        base = el_n; b1 = r1_err; b3 = r3_err; b4 = r4_err; b5 = r5_err;

        cfg_init_dly = DLY_W'(init);
        cfg_mult     = MULT_W'(mult);
        cfg_tref     = DLY_W'(tref);
        cfg_res      = DLY_W'(res);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9", {name, " busy after start"}, int'(busy), 1);
        chk(done === 1'b0, "R9", {name, " done cleared by start"}, int'(done), 0);

        if (disturb) begin
            // R9: a start while busy with other settings changes nothing
            repeat (40) @(negedge clk);
            cfg_init_dly = DLY_W'(3);
            cfg_mult     = MULT_W'(7);
            cfg_tref     = DLY_W'(50);
            cfg_res      = DLY_W'(30);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end

        lim = 0;
        while (!done && lim < 60000 && cyc < 190000) begin
            @(negedge clk);
            lim++;
        end
        chk(done === 1'b1, "R9", {name, " done reached (watchdog)"}, int'(done), 1);
        chk(busy === 1'b0, "R9", {name, " busy low at done"}, int'(busy), 0);
        chk(no_tail === exp_nt, "R8", {name, " no_tail"}, int'(no_tail), int'(exp_nt));
        chk(int'(tail_dly) == exp_tail, "R7", {name, " tail_dly"}, int'(tail_dly), exp_tail);
        chk(el_n - base == exp_n, "R6", {name, " pass count"}, el_n - base, exp_n);
        for (int k = 0; k < exp_n && base + k < LOGSZ; k++)
            chk(el_log[base + k] == wait_of(exp_d[k]), "R2",
                $sformatf("%s pass %0d cell wait", name, k),
                el_log[base + k], wait_of(exp_d[k]));
        chk(r1_err == b1, "R1", {name, " write burst"}, r1_err - b1, 0);
        chk(r3_err == b3, "R3", {name, " read burst"}, r3_err - b3, 0);
        chk(r4_err == b4, "R4", {name, " fail stream"}, r4_err - b4, 0);
        chk(pass_fail === exp_lastfail, "R5", {name, " pass_fail at done"},
            int'(pass_fail), int'(exp_lastfail));
        lastpf = pass_fail;
        repeat (10) @(negedge clk);
        chk(pass_fail === lastpf, "R5", {name, " pass_fail held"}, int'(pass_fail), int'(lastpf));
        chk(done === 1'b1, "R9", {name, " done held"}, int'(done), 1);
        chk(r5_err == b5, "R5", {name, " cleared at pass start"}, r5_err - b5, 0);
    endtask

    task automatic set_holds(input int base_hold, input int weak_cell, input int weak_hold);
        for (int i = 0; i < CELLS; i++) hold[i] = base_hold;
        if (weak_cell >= 0) hold[weak_cell] = weak_hold;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(20240611);
        // R10 reset state
        repeat (5) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_we === 1'b0 && mem_re === 1'b0, "R10", "no access after reset",
            int'({mem_we, mem_re}), 0);
        chk(fail_valid === 1'b0 && no_tail === 1'b0, "R10", "fail_valid/no_tail after reset",
            int'({fail_valid, no_tail}), 0);
        repeat (8) @(negedge clk);
        chk(busy === 1'b0 && mem_we === 1'b0, "R10", "idle without start",
            int'({busy, mem_we}), 0);

        // R6/R7 directed: one weak cell, with a mid-run start (R9)
        set_holds(300, 9, 100);
        run_case("weak_cell", 10, 2, 500, 4, 1'b1);
        // R8 directed: nothing fails at the limit
        set_holds(900, -1, 0);
        run_case("no_tail", 20, 3, 400, 8, 1'b0);
        // R6/R7 directed: multiplier 1 acts as 2, resolution 0 acts as 1, init 0 acts as 1
        set_holds(250, 3, 137);
        run_case("exact", 0, 1, 480, 0, 1'b0);
        // R7 directed: cell fails below the burst length, first pass fails
        set_holds(400, 5, 5);
        run_case("below_burst", 4, 2, 300, 0, 1'b0);
        // R6 directed: init above limit clamps to limit
        set_holds(200, -1, 0);
        run_case("init_clamp", 900, 4, 150, 2, 1'b0);

        // constrained random
        for (int n = 0; n < 5; n++) begin
            for (int i = 0; i < CELLS; i++) hold[i] = $urandom_range(600, 60);
            if ($urandom_range(1, 0) == 1)
                hold[$urandom_range(CELLS - 1, 0)] = $urandom_range(120, 2);
            run_case($sformatf("rand%0d", n), $urandom_range(60, 0), $urandom_range(7, 0),
                     $urandom_range(500, 100), $urandom_range(20, 0), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule